// File: doc/BRIEF.md
# Twelve-Channel DMA Request Arbiter

This block decides which of twelve DMA channels may use the bus. Each channel takes its transfer request from one of three places, chosen by a 4-bit source field. Auto mode raises the request internally. External mode uses a level request pin, which exists only on the four lowest channels. Peripheral mode uses one bit of a peripheral request vector. A channel may request only while it is allowed to run. That needs its own enable, its group's master enable, a clear end flag, and no address error or NMI pending in its group.

Channels 0 to 5 form group 0 and channels 6 to 11 form group 1. Each group has its own enable, address-error and NMI inputs. Priority between pending channels is fixed. The winner is granted the bus and counts transfer units down from a loaded value. In burst mode it keeps the bus until its count runs out. In cycle-steal mode it hands the bus back after every unit. The address path, data path and bus protocol live elsewhere; they report each finished transfer unit with a one-cycle done pulse.

Top module: `dma_req_ctrl`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, grant_o, bus_req_o and tend_o are all zero.
- R2: A channel raises no request unless all of these hold: ch_en_i[c] is 1, the group enable is 1, tend_o[c] is 0, the group address-error input is 0 and the group NMI input is 0. The group is bit 0 of grp_*_i for channels 0-5 and bit 1 for channels 6-11.
- R3: The source field src_sel_i[4c+3:4c] works as follows. 4'b0000 requests whenever the channel is eligible. 4'b0001 selects the external line. 4'b0010 selects per_req_i[c], which is used without synchronization, so a grant follows one edge later. Every other value requests nothing.
- R4: External lines exist only for channels 0-3 and pass through a two-flop synchronizer, so an idle bus grants at the third rising edge after ext_req_i[c] goes high. A channel 4-11 in external mode never requests.
- R5: When the bus is idle, the lowest-numbered requesting channel is granted on the next edge. At most one grant_o bit is high, and bus_req_o is high exactly when one is.
- R6: A burst channel keeps its grant across unit_done_i pulses while it still requests and its count has not run out.
- R7: A cycle-steal channel loses its grant on every unit_done_i pulse. Arbitration runs again on the following edge.
- R8: cnt_load_i[c] loads cnt_val_i into the channel's count, and each unit_done_i pulse on the granted channel decrements it. On the pulse that finds the count at 1, tend_o[c] is set and the grant is dropped on the same edge. tend_o[c] holds until tend_clr_i[c].
- R9: Raising a group's address-error or NMI input does not remove a live grant mid-unit. The grant is withdrawn at the next unit_done_i pulse, and channels of the other group stay eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_en_i | input | 2 | Master enable per group |
| grp_aerr_i | input | 2 | Address-error flag per group |
| grp_nmi_i | input | 2 | NMI flag per group |
| ch_en_i | input | 12 | Per-channel enable |
| src_sel_i | input | 48 | 4-bit request source field per channel |
| burst_i | input | 12 | 1 = burst, 0 = cycle steal |
| cnt_load_i | input | 12 | Load pulse for the channel's transfer count |
| cnt_val_i | input | 24 | Count value used by the load |
| tend_clr_i | input | 12 | Clears the channel's end flag |
| ext_req_i | input | 4 | External level requests, channels 0-3 |
| per_req_i | input | 12 | Peripheral request per channel |
| unit_done_i | input | 1 | One-cycle pulse: granted channel finished a unit |
| grant_o | output | 12 | One-hot bus grant |
| bus_req_o | output | 1 | Bus requested by the granted channel |
| tend_o | output | 12 | Transfer-end flags |

## Verification
A wrong count or a lost end flag shows at tend_o on the edge of the final unit_done_i pulse. It also shows one edge later, when a channel that should have retired is granted again. A stuck owner register or wrong priority decode is visible on grant_o one edge after the bus goes idle. A synchronizer with the wrong depth moves the external-mode grant by a whole cycle. A missing group gate shows as a grant that persists after the boundary unit_done_i pulse.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int unsigned SRC_AUTO = 0;
  localparam int unsigned SRC_EXT  = 1;
  localparam int unsigned SRC_PERI = 2;
  localparam int unsigned NUM_GRP  = 2;
endpackage

// File: rtl/dma_ext_sync.sv
module dma_ext_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             done_i,
  output logic             last_o,
  output logic             tend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tend_q;

  assign last_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (done_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q <= 1'b0;
    end else if (done_i && last_o && !load_i) begin
      tend_q <= 1'b1;
    end else if (clr_i) begin
      tend_q <= 1'b0;
    end
  end

  assign tend_o = tend_q;

  a_r8_cnt_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r8_tend_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_q) |-> $past(done_i));
  a_r8_tend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> !tend_q);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] burst_i,
  input  logic [N-1:0] last_i,
  input  logic         done_i,
  output logic [N-1:0] grant_o,
  output logic         busy_o
);
  logic [N-1:0] gnt_q, pick;
  logic         found, rel;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  // release only at a unit boundary
  assign rel = done_i && |(gnt_q & (~burst_i | last_i | ~req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
    end else if (|gnt_q) begin
      if (rel) gnt_q <= '0;
    end else begin
      gnt_q <= pick;
    end
  end

  assign grant_o = gnt_q;
  assign busy_o  = |gnt_q;

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  a_r7_steal_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && |(gnt_q & ~burst_i)) |=> (gnt_q == '0));
  a_r6_hold_mid_unit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_q && !done_i) |=> $stable(gnt_q));

  for (genvar i = 0; i < int'(N); i++) begin : g_chk
    a_r5_grant_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_q[i]) |-> $past(req_i[i]));
  end
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int unsigned NUM_CH    = 12,
  parameter int unsigned NUM_EXT   = 4,
  parameter int unsigned GRP_SPLIT = 6,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned SEL_W     = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_GRP-1:0]      grp_en_i,
  input  logic [NUM_GRP-1:0]      grp_aerr_i,
  input  logic [NUM_GRP-1:0]      grp_nmi_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH*SEL_W-1:0] src_sel_i,
  input  logic [NUM_CH-1:0]       burst_i,
  input  logic [NUM_CH-1:0]       cnt_load_i,
  input  logic [CNT_W-1:0]        cnt_val_i,
  input  logic [NUM_CH-1:0]       tend_clr_i,
  input  logic [NUM_EXT-1:0]      ext_req_i,
  input  logic [NUM_CH-1:0]       per_req_i,
  input  logic                    unit_done_i,
  output logic [NUM_CH-1:0]       grant_o,
  output logic                    bus_req_o,
  output logic [NUM_CH-1:0]       tend_o
);
  logic [NUM_EXT-1:0] ext_s;
  logic [NUM_CH-1:0]  req, last, tend;
  logic [NUM_CH-1:0]  gnt;

  dma_ext_sync #(.W(NUM_EXT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_req_i),
    .q_o   (ext_s)
  );

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    localparam int unsigned G = (c < int'(GRP_SPLIT)) ? 0 : 1;
    logic [SEL_W-1:0] sel;
    logic             elig, ext_hit, src_hit;

    assign sel  = src_sel_i[c*SEL_W +: SEL_W];
    assign elig = ch_en_i[c] && grp_en_i[G] && !tend[c] &&
                  !grp_aerr_i[G] && !grp_nmi_i[G];

    if (c < int'(NUM_EXT)) begin : g_ext
      assign ext_hit = ext_s[c];
    end else begin : g_noext
      assign ext_hit = 1'b0;
    end

    always_comb begin
      unique case (sel)
        SEL_W'(SRC_AUTO): src_hit = 1'b1;
        SEL_W'(SRC_EXT):  src_hit = ext_hit;
        SEL_W'(SRC_PERI): src_hit = per_req_i[c];
        default:          src_hit = 1'b0;
      endcase
    end

    assign req[c] = elig && src_hit;

    dma_chan_ctx #(.CNT_W(CNT_W)) u_ctx (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (cnt_load_i[c]),
      .load_val_i(cnt_val_i),
      .clr_i     (tend_clr_i[c]),
      .done_i    (unit_done_i && gnt[c]),
      .last_o    (last[c]),
      .tend_o    (tend[c])
    );

    a_r9_abort_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unit_done_i && gnt[c] && (grp_aerr_i[G] || grp_nmi_i[G])) |=> !gnt[c]);
    a_r2_no_grant_when_ended: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tend[c] && !gnt[c]) |=> !gnt[c]);
  end

  dma_prio_arb #(.N(NUM_CH)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .burst_i(burst_i),
    .last_i (last),
    .done_i (unit_done_i),
    .grant_o(gnt),
    .busy_o (bus_req_o)
  );

  assign grant_o = gnt;
  assign tend_o  = tend;
endmodule

// File: tb/dma_req_ctrl_bench.sv
`timescale 1ns/1ps
module dma_req_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  grp_en = '0, grp_aerr = '0, grp_nmi = '0;
  logic [11:0] ch_en = '0, burst = '0, cnt_load = '0, tend_clr = '0, per_req = '0;
  logic [47:0] src_sel = '0;
  logic [23:0] cnt_val = '0;
  logic [3:0]  ext_req = '0;
  logic        unit_done = 1'b0;
  logic [11:0] grant_o, tend_o;
  logic        bus_req_o;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  string       q_tag[$];
  logic [11:0] q_g[$], q_t[$];

  always #2.5 clk_i = ~clk_i;

  dma_req_ctrl u_dma_req_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .grp_en_i(grp_en), .grp_aerr_i(grp_aerr), .grp_nmi_i(grp_nmi),
    .ch_en_i(ch_en), .src_sel_i(src_sel), .burst_i(burst),
    .cnt_load_i(cnt_load), .cnt_val_i(cnt_val), .tend_clr_i(tend_clr),
    .ext_req_i(ext_req), .per_req_i(per_req), .unit_done_i(unit_done),
    .grant_o(grant_o), .bus_req_o(bus_req_o), .tend_o(tend_o)
  );

  // monitor: pop and compare away from the active edge
  always @(negedge clk_i) begin
    if (q_tag.size() > 0) begin
      string tg;
      logic [11:0] eg, et;
      tg = q_tag.pop_front();
      eg = q_g.pop_front();
      et = q_t.pop_front();
      n_vec++;
      if (grant_o !== eg || tend_o !== et || bus_req_o !== (|eg)) begin
        n_bad++;
        $display("FAIL %s: grant=%h tend=%h bus=%b expected grant=%h tend=%h bus=%b",
                 tg, grant_o, tend_o, bus_req_o, eg, et, |eg);
      end
    end
  end

  task automatic expect_out(string tag, logic [11:0] g, logic [11:0] t);
    q_tag.push_back(tag);
    q_g.push_back(g);
    q_t.push_back(t);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic unit();
    unit_done = 1'b1;
    step(1);
    unit_done = 1'b0;
  endtask

  task automatic set_sel(int c, logic [3:0] v);
    src_sel[c*4 +: 4] = v;
  endtask

  task automatic load(logic [11:0] m, logic [23:0] v);
    cnt_load = m;
    cnt_val  = v;
  endtask

  task automatic wipe();
    ch_en = '0; burst = '0; per_req = '0; ext_req = '0;
    grp_aerr = '0; grp_nmi = '0; src_sel = '0;
    tend_clr = '1;
    step(1);
    tend_clr = '0;
  endtask

  initial begin
    step(3);
    expect_out("R1 reset", 12'h000, 12'h000);
    rst_ni = 1'b1;
    step(1);
    expect_out("R1 after reset", 12'h000, 12'h000);
    grp_en = 2'b11;

    // burst, auto, count 3 on ch5
    ch_en[5] = 1'b1; burst[5] = 1'b1; set_sel(5, 4'b0000);
    load(12'h020, 24'd3);
    step(1); cnt_load = '0;
    expect_out("R5 auto grant ch5", 12'h020, 12'h000);
    unit(); expect_out("R6 burst hold 1", 12'h020, 12'h000);
    unit(); expect_out("R6 burst hold 2", 12'h020, 12'h000);
    unit(); expect_out("R8 count end ch5", 12'h000, 12'h020);
    step(1); expect_out("R2 ended ch blocked", 12'h000, 12'h020);
    ch_en[5] = 1'b0; tend_clr[5] = 1'b1;
    step(1); tend_clr = '0;
    expect_out("R8 tend clear", 12'h000, 12'h000);

    // cycle steal, priority ch2 over ch7
    ch_en[2] = 1'b1; ch_en[7] = 1'b1;
    load(12'h084, 24'd2);
    step(1); cnt_load = '0;
    expect_out("R5 priority ch2", 12'h004, 12'h000);
    unit(); expect_out("R7 steal release", 12'h000, 12'h000);
    step(1); expect_out("R7 rearbitrate ch2", 12'h004, 12'h000);
    unit(); expect_out("R8 ch2 end", 12'h000, 12'h004);
    step(1); expect_out("R5 ch7 next", 12'h080, 12'h004);
    unit(); expect_out("R7 ch7 release", 12'h000, 12'h004);
    step(1); expect_out("R7 ch7 regrant", 12'h080, 12'h004);
    unit(); expect_out("R8 ch7 end", 12'h000, 12'h084);
    wipe();
    expect_out("R8 wipe", 12'h000, 12'h000);

    // external mode on ch4 and reserved code
    ch_en[4] = 1'b1; set_sel(4, 4'b0001); ext_req = 4'hF; per_req = '1;
    step(4); expect_out("R4 no ext on ch4", 12'h000, 12'h000);
    set_sel(4, 4'b0111);
    step(2); expect_out("R3 reserved code", 12'h000, 12'h000);
    ch_en[4] = 1'b0; set_sel(4, 4'b0000); ext_req = '0; per_req = '0;
    step(3);

    // external mode on ch1, sync latency
    ch_en[1] = 1'b1; burst[1] = 1'b1; set_sel(1, 4'b0001); ext_req[1] = 1'b1;
    load(12'h002, 24'd1);
    step(1); cnt_load = '0;
    step(1); expect_out("R4 sync delay", 12'h000, 12'h000);
    step(1); expect_out("R4 ext grant ch1", 12'h002, 12'h000);
    unit(); expect_out("R8 single unit", 12'h000, 12'h002);
    wipe();

    // peripheral mode on ch9, group gating
    grp_en = 2'b01;
    ch_en[9] = 1'b1; burst[9] = 1'b1; set_sel(9, 4'b0010); per_req[9] = 1'b1;
    load(12'h200, 24'd4);
    step(1); cnt_load = '0;
    step(1); expect_out("R2 group disabled", 12'h000, 12'h000);
    grp_en = 2'b11; per_req[9] = 1'b0;
    step(2); expect_out("R3 peri low", 12'h000, 12'h000);
    per_req[9] = 1'b1;
    step(1); expect_out("R3 peri grant", 12'h200, 12'h000);

    // address error withdraws at boundary
    grp_aerr[1] = 1'b1;
    step(1); expect_out("R9 hold mid unit", 12'h200, 12'h000);
    unit(); expect_out("R9 aerr release", 12'h000, 12'h000);
    step(1); expect_out("R2 aerr blocks", 12'h000, 12'h000);
    grp_aerr[1] = 1'b0;
    step(1); expect_out("R9 regrant after clear", 12'h200, 12'h000);
    ch_en[9] = 1'b0;
    unit(); expect_out("R6 burst drop on no req", 12'h000, 12'h000);
    wipe();

    // NMI on group 0, group 1 unaffected
    ch_en[0] = 1'b1; ch_en[6] = 1'b1; burst[0] = 1'b1; burst[6] = 1'b1;
    load(12'h041, 24'd5);
    step(1); cnt_load = '0;
    expect_out("R5 ch0 first", 12'h001, 12'h000);
    grp_nmi[0] = 1'b1;
    unit(); expect_out("R9 nmi release", 12'h000, 12'h000);
    step(1); expect_out("R9 other group", 12'h040, 12'h000);
    grp_nmi[0] = 1'b0; ch_en = '0;
    unit(); expect_out("R6 ch6 drop", 12'h000, 12'h000);
    step(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule